// File: doc/BRIEF.md
# Address Window Access Checker

This block classifies each physical bus access against a small set of programmable address windows (two by default). Each window holds an enable, a two-bit privilege selector, an eight-bit base, an eight-bit mask, two user attribute bits, a two-bit cache mode and a write-protect flag. The checker samples an access on a request strobe. In the following cycle it reports whether a window claims the access, which window it is, the cache mode and user attributes of that window, and an abort when a protected window is written.

Only the most significant byte of the physical address takes part in the compare, and the access port carries that byte alone. A set mask bit drops the matching base bit from the compare, so a window grows as higher mask bits are set. The user attribute bits are not interpreted. They go straight to the outputs so that the bus side can echo them on an external transfer. A programming port loads one window per cycle.

A two-state controller sequences the work. `ST_IDLE` means no access is held. `ST_EVAL` means an access was captured at the last edge and the outputs describe it. There are four transitions: IDLE→EVAL on a request, EVAL→EVAL on a back-to-back request, EVAL→IDLE when no request arrives, and IDLE→IDLE otherwise.

Top module: `addr_window_check`

## Requirements
- R1: After reset every window is disabled, the controller is in ST_IDLE, and hit, abort, cache mode, user attributes and hit index all read zero.
- R2: A window whose enable bit is 0 never produces a hit, whatever its other fields hold.
- R3: A window hits only when every address-byte bit whose mask bit is 0 equals the corresponding base bit; address-byte bits whose mask bit is 1 are ignored.
- R4: The privilege selector of a window is decoded as 00 = user accesses only (super=0), 01 = supervisor accesses only (super=1), 10 and 11 = either mode.
- R5: When several windows hit, the one with the lowest index is reported, and its index appears on hit_idx_o.
- R6: With no hit, the outputs are hit 0, cache mode 00 (cachable write-through), user attributes 00 and abort 0.
- R7: abort_o is 1 exactly when the reported window has write protect set and the access is a write or a read-modify-write; reads through a protected window do not abort.
- R8: On a hit, cmode_o carries the reported window's two-bit cache mode unchanged (00 write-through, 01 copyback, 10 noncachable serialized, 11 noncachable), and uattr_o carries its two user attribute bits unchanged.
- R9: An access presented with acc_req_i=1 before a rising edge is reported during the cycle that follows that edge. A cycle without a request leaves hit and abort at 0 in the next cycle.
- R10: A window write takes effect at the rising edge that samples cfg_we_i=1. An access sampled at that same edge is judged against the newly written window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Window write strobe |
| cfg_sel_i | input | IDX_W | Window index to write |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_priv_i | input | 2 | Privilege selector to write |
| cfg_base_i | input | 8 | Base byte to write |
| cfg_mask_i | input | 8 | Mask byte to write (1 = ignore bit) |
| cfg_uattr_i | input | 2 | User attribute bits to write |
| cfg_cmode_i | input | 2 | Cache mode to write |
| cfg_wprot_i | input | 1 | Write-protect flag to write |
| acc_req_i | input | 1 | Access request strobe |
| acc_addr_hi_i | input | 8 | Most significant byte of the physical address |
| acc_super_i | input | 1 | 1 = supervisor access, 0 = user access |
| acc_write_i | input | 1 | Access is a write |
| acc_rmw_i | input | 1 | Access is a read-modify-write |
| hit_o | output | 1 | A window claims the access |
| hit_idx_o | output | IDX_W | Index of the reported window |
| cmode_o | output | 2 | Cache mode of the reported window |
| uattr_o | output | 2 | User attribute bits of the reported window |
| abort_o | output | 1 | Protected write: access error |

## Verification
A window write and an access can fall on the same edge. When they do, the access must be judged against the new window contents and not the old ones. The bench provokes this directly: one edge disables a window that hits while the same edge samples an access that would match it, and another edge turns a miss into a protected hit. The random phase also mixes writes into access cycles. The bench updates its own record of the windows at that edge and predicts the outputs from it, so a design that lags the write by a cycle shows a mismatch in hit, cache mode or abort.

// File: rtl/addr_window_pkg.sv
package addr_window_pkg;

    localparam int TAG_W = 8;

    typedef struct packed {
        logic             en;
        logic [1:0]       priv;
        logic [TAG_W-1:0] base;
        logic [TAG_W-1:0] mask;
        logic [1:0]       uattr;
        logic [1:0]       cmode;
        logic             wprot;
    } win_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } acc_state_e;

endpackage

// File: rtl/addr_window_bank.sv
module addr_window_bank
    import addr_window_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     we_i,
    input  logic [IDX_W-1:0]         sel_i,
    input  win_cfg_t                 wdata_i,
    output win_cfg_t [NUM_WIN-1:0]   cfg_o
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cfg_o[g] <= '0;
            end else if (we_i && (sel_i == IDX_W'(g))) begin
                cfg_o[g] <= wdata_i;
            end
        end
    end

endmodule

// File: rtl/addr_window_match.sv
module addr_window_match
    import addr_window_pkg::*;
(
    input  logic             en_i,
    input  logic [1:0]       priv_i,
    input  logic [TAG_W-1:0] base_i,
    input  logic [TAG_W-1:0] mask_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             super_i,
    output logic             match_o
);

    logic addr_ok;
    logic priv_ok;

    always_comb begin
        addr_ok = (((tag_i ^ base_i) & ~mask_i) == '0);
        priv_ok = priv_i[1] | (priv_i[0] == super_i);
        match_o = en_i & addr_ok & priv_ok;
    end

endmodule

// File: rtl/addr_window_prio.sv
module addr_window_prio
    import addr_window_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 1
) (
    input  logic [NUM_WIN-1:0]       match_i,
    input  win_cfg_t [NUM_WIN-1:0]   cfg_i,
    output logic                     any_o,
    output logic [IDX_W-1:0]         idx_o,
    output win_cfg_t                 sel_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        sel_o = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
                sel_o = cfg_i[i];
            end
        end
    end

endmodule

// File: rtl/addr_window_check.sv
module addr_window_check
    import addr_window_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_sel_i,
    input  logic             cfg_en_i,
    input  logic [1:0]       cfg_priv_i,
    input  logic [7:0]       cfg_base_i,
    input  logic [7:0]       cfg_mask_i,
    input  logic [1:0]       cfg_uattr_i,
    input  logic [1:0]       cfg_cmode_i,
    input  logic             cfg_wprot_i,
    input  logic             acc_req_i,
    input  logic [7:0]       acc_addr_hi_i,
    input  logic             acc_super_i,
    input  logic             acc_write_i,
    input  logic             acc_rmw_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] hit_idx_o,
    output logic [1:0]       cmode_o,
    output logic [1:0]       uattr_o,
    output logic             abort_o
);

    acc_state_e             state_q, state_d;
    logic [TAG_W-1:0]       tag_q;
    logic                   super_q, wr_q, rmw_q;
    win_cfg_t               wdata;
    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     win_hit;
    logic                   any_hit;
    logic [IDX_W-1:0]       sel_idx;
    win_cfg_t               sel_cfg;

    always_comb begin
        wdata.en    = cfg_en_i;
        wdata.priv  = cfg_priv_i;
        wdata.base  = cfg_base_i;
        wdata.mask  = cfg_mask_i;
        wdata.uattr = cfg_uattr_i;
        wdata.cmode = cfg_cmode_i;
        wdata.wprot = cfg_wprot_i;
    end

    addr_window_bank #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) i_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (wdata),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        addr_window_match i_match (
            .en_i    (cfg[g].en),
            .priv_i  (cfg[g].priv),
            .base_i  (cfg[g].base),
            .mask_i  (cfg[g].mask),
            .tag_i   (tag_q),
            .super_i (super_q),
            .match_o (win_hit[g])
        );
    end

    addr_window_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) i_prio (
        .match_i (win_hit),
        .cfg_i   (cfg),
        .any_o   (any_hit),
        .idx_o   (sel_idx),
        .sel_o   (sel_cfg)
    );

    // state register and captured access
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            tag_q   <= '0;
            super_q <= 1'b0;
            wr_q    <= 1'b0;
            rmw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (acc_req_i) begin
                tag_q   <= acc_addr_hi_i;
                super_q <= acc_super_i;
                wr_q    <= acc_write_i;
                rmw_q   <= acc_rmw_i;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = acc_req_i ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = acc_req_i ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        cmode_o   = 2'b00;
        uattr_o   = 2'b00;
        abort_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EVAL: begin
                if (any_hit) begin
                    hit_o     = 1'b1;
                    hit_idx_o = sel_idx;
                    cmode_o   = sel_cfg.cmode;
                    uattr_o   = sel_cfg.uattr;
                    abort_o   = sel_cfg.wprot & (wr_q | rmw_q);
                end
            end
            default: ;
        endcase
    end

    // R6
    nohit_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> (cmode_o == 2'b00 && uattr_o == 2'b00 && !abort_o));

    // R7
    abort_needs_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> (hit_o && (wr_q || rmw_q)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |-> (!hit_o && !abort_o));

    // R9
    eval_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_EVAL) |-> $past(acc_req_i));

    // R5
    low_index_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_EVAL && win_hit[0]) |-> (hit_o && hit_idx_o == '0));

    // R2
    hit_window_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> cfg[hit_idx_o].en);

endmodule

// File: tb/test_addr_window_check.sv
module test_addr_window_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [0:0] cfg_sel = '0;
    logic       cfg_en = 1'b0;
    logic [1:0] cfg_priv = '0;
    logic [7:0] cfg_base = '0;
    logic [7:0] cfg_mask = '0;
    logic [1:0] cfg_uattr = '0;
    logic [1:0] cfg_cmode = '0;
    logic       cfg_wprot = 1'b0;
    logic       acc_req = 1'b0;
    logic [7:0] acc_hi = '0;
    logic       acc_super = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_rmw = 1'b0;
    logic       hit;
    logic [0:0] hit_idx;
    logic [1:0] cmode;
    logic [1:0] uattr;
    logic       abort;

    int checks = 0;
    int failures = 0;

    // bench record of the windows as programmed
    logic       s_en[2];
    logic [1:0] s_priv[2];
    logic [7:0] s_base[2];
    logic [7:0] s_mask[2];
    logic [1:0] s_uattr[2];
    logic [1:0] s_cmode[2];
    logic       s_wp[2];

    always #5 clk = ~clk;

    addr_window_check i_addr_window_check (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_en_i(cfg_en),
        .cfg_priv_i(cfg_priv), .cfg_base_i(cfg_base), .cfg_mask_i(cfg_mask),
        .cfg_uattr_i(cfg_uattr), .cfg_cmode_i(cfg_cmode), .cfg_wprot_i(cfg_wprot),
        .acc_req_i(acc_req), .acc_addr_hi_i(acc_hi), .acc_super_i(acc_super),
        .acc_write_i(acc_write), .acc_rmw_i(acc_rmw),
        .hit_o(hit), .hit_idx_o(hit_idx), .cmode_o(cmode), .uattr_o(uattr),
        .abort_o(abort)
    );

    function automatic logic win_match(int w, logic [7:0] a, logic s);
        logic pok;
        pok = s_priv[w][1] | (s_priv[w][0] == s);
        return s_en[w] && (((a ^ s_base[w]) & ~s_mask[w]) == 8'h00) && pok;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: optional window write, optional access, then check outputs
    task automatic cycle(string req,
                         logic do_cfg, logic sel, logic en, logic [1:0] pv,
                         logic [7:0] base, logic [7:0] mask, logic [1:0] ua,
                         logic [1:0] cm, logic wp,
                         logic do_acc, logic [7:0] a, logic s, logic wr, logic rmw);
        logic       e_hit, e_abort;
        logic [0:0] e_idx;
        logic [1:0] e_cm, e_ua;
        @(negedge clk);
        cfg_we = do_cfg; cfg_sel = sel; cfg_en = en; cfg_priv = pv;
        cfg_base = base; cfg_mask = mask; cfg_uattr = ua; cfg_cmode = cm; cfg_wprot = wp;
        acc_req = do_acc; acc_hi = a; acc_super = s; acc_write = wr; acc_rmw = rmw;
        @(posedge clk);
        if (do_cfg) begin
            s_en[sel] = en; s_priv[sel] = pv; s_base[sel] = base; s_mask[sel] = mask;
            s_uattr[sel] = ua; s_cmode[sel] = cm; s_wp[sel] = wp;
        end
        #1;
        cfg_we = 1'b0; acc_req = 1'b0;
        e_hit = 1'b0; e_idx = '0; e_cm = 2'b00; e_ua = 2'b00; e_abort = 1'b0;
        if (do_acc) begin
            for (int w = 1; w >= 0; w--) begin
                if (win_match(w, a, s)) begin
                    e_hit = 1'b1; e_idx = 1'(w); e_cm = s_cmode[w]; e_ua = s_uattr[w];
                    e_abort = s_wp[w] & (wr | rmw);
                end
            end
        end
        check({req, " hit"},   {7'd0, hit},   {7'd0, e_hit});
        check({req, " idx"},   {7'd0, hit_idx}, {7'd0, e_idx});
        check({req, " cmode"}, {6'd0, cmode}, {6'd0, e_cm});
        check({req, " uattr"}, {6'd0, uattr}, {6'd0, e_ua});
        check({req, " abort"}, {7'd0, abort}, {7'd0, e_abort});
    endtask

    task automatic wcfg(string req, logic sel, logic en, logic [1:0] pv, logic [7:0] base,
                        logic [7:0] mask, logic [1:0] ua, logic [1:0] cm, logic wp);
        cycle(req, 1'b1, sel, en, pv, base, mask, ua, cm, wp, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic acc(string req, logic [7:0] a, logic s, logic wr, logic rmw);
        cycle(req, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0, 1'b1, a, s, wr, rmw);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] r_base, r_mask, r_a;
        void'($urandom(32'd2024));
        for (int w = 0; w < 2; w++) begin
            s_en[w] = 0; s_priv[w] = 0; s_base[w] = 0; s_mask[w] = 0;
            s_uattr[w] = 0; s_cmode[w] = 0; s_wp[w] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state visible at the ports
        check("R1 hit", {7'd0, hit}, 8'd0);
        check("R1 abort", {7'd0, abort}, 8'd0);
        check("R1 cmode", {6'd0, cmode}, 8'd0);
        rst_n = 1'b1;
        // R1: windows disabled after reset, any access misses
        acc("R1", 8'h00, 1'b1, 1'b1, 1'b0);
        acc("R1", 8'hFF, 1'b0, 1'b0, 1'b0);

        // R2: disabled window with catch-all fields never hits
        wcfg("R2", 1'b0, 1'b0, 2'b10, 8'h00, 8'hFF, 2'b11, 2'b11, 1'b1);
        acc("R2", 8'h5A, 1'b1, 1'b1, 1'b0);
        check("R2 direct", {7'd0, hit}, 8'd0);

        // R3: exact and masked compares
        wcfg("R3", 1'b0, 1'b1, 2'b10, 8'hA5, 8'h00, 2'b00, 2'b01, 1'b0);
        acc("R3", 8'hA5, 1'b0, 1'b0, 1'b0);
        check("R3 exact hit", {7'd0, hit}, 8'd1);
        acc("R3", 8'hA4, 1'b0, 1'b0, 1'b0);
        check("R3 one bit off", {7'd0, hit}, 8'd0);
        wcfg("R3", 1'b0, 1'b1, 2'b10, 8'hA0, 8'h0F, 2'b00, 2'b01, 1'b0);
        acc("R3", 8'hAF, 1'b1, 1'b0, 1'b0);
        check("R3 masked hit", {7'd0, hit}, 8'd1);
        acc("R3", 8'hB0, 1'b1, 1'b0, 1'b0);
        check("R3 unmasked miss", {7'd0, hit}, 8'd0);

        // R4: privilege selector
        wcfg("R4", 1'b0, 1'b1, 2'b00, 8'h10, 8'h00, 2'b00, 2'b00, 1'b0);
        acc("R4", 8'h10, 1'b0, 1'b0, 1'b0);
        check("R4 user-only user", {7'd0, hit}, 8'd1);
        acc("R4", 8'h10, 1'b1, 1'b0, 1'b0);
        check("R4 user-only super", {7'd0, hit}, 8'd0);
        wcfg("R4", 1'b0, 1'b1, 2'b01, 8'h10, 8'h00, 2'b00, 2'b00, 1'b0);
        acc("R4", 8'h10, 1'b0, 1'b0, 1'b0);
        check("R4 super-only user", {7'd0, hit}, 8'd0);
        acc("R4", 8'h10, 1'b1, 1'b0, 1'b0);
        wcfg("R4", 1'b0, 1'b1, 2'b11, 8'h10, 8'h00, 2'b00, 2'b00, 1'b0);
        acc("R4", 8'h10, 1'b0, 1'b0, 1'b0);
        acc("R4", 8'h10, 1'b1, 1'b0, 1'b0);
        check("R4 either super", {7'd0, hit}, 8'd1);

        // R5: overlapping windows, lower index wins
        wcfg("R5", 1'b0, 1'b1, 2'b10, 8'h40, 8'h3F, 2'b01, 2'b10, 1'b0);
        wcfg("R5", 1'b1, 1'b1, 2'b10, 8'h40, 8'h0F, 2'b10, 2'b11, 1'b1);
        acc("R5", 8'h45, 1'b1, 1'b1, 1'b0);
        check("R5 idx0", {6'd0, hit, hit_idx}, 8'b10);
        check("R5 no abort from idx1", {7'd0, abort}, 8'd0);

        // R8: only window 1 hits, its fields pass through
        acc("R8", 8'h7F, 1'b0, 1'b0, 1'b0);
        wcfg("R8", 1'b0, 1'b0, 2'b10, 8'h40, 8'h3F, 2'b01, 2'b10, 1'b0);
        acc("R8", 8'h45, 1'b0, 1'b0, 1'b0);
        check("R8 cmode", {6'd0, cmode}, 8'd3);
        check("R8 uattr", {6'd0, uattr}, 8'd2);

        // R6: miss defaults
        acc("R6", 8'hC3, 1'b1, 1'b1, 1'b1);
        check("R6 cmode default", {6'd0, cmode}, 8'd0);

        // R7: write protection by access kind
        acc("R7", 8'h41, 1'b0, 1'b0, 1'b0);
        check("R7 read no abort", {7'd0, abort}, 8'd0);
        acc("R7", 8'h41, 1'b0, 1'b1, 1'b0);
        check("R7 write abort", {7'd0, abort}, 8'd1);
        acc("R7", 8'h41, 1'b0, 1'b0, 1'b1);
        check("R7 rmw abort", {7'd0, abort}, 8'd1);
        wcfg("R7", 1'b1, 1'b1, 2'b10, 8'h40, 8'h0F, 2'b10, 2'b11, 1'b0);
        acc("R7", 8'h41, 1'b0, 1'b1, 1'b0);
        check("R7 unprotected write", {7'd0, abort}, 8'd0);

        // R9: cycle without request reports nothing
        acc("R9", 8'h41, 1'b0, 1'b0, 1'b0);
        cycle("R9 idle", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 2'b00, 2'b00, 1'b0,
              1'b0, 8'h41, 1'b0, 1'b0, 1'b0);
        check("R9 idle hit", {7'd0, hit}, 8'd0);

        // R10: write and access on the same edge
        cycle("R10 disable", 1'b1, 1'b1, 1'b0, 2'b10, 8'h40, 8'h0F, 2'b10, 2'b11, 1'b0,
              1'b1, 8'h41, 1'b0, 1'b0, 1'b0);
        check("R10 disable same edge", {7'd0, hit}, 8'd0);
        cycle("R10 protect", 1'b1, 1'b0, 1'b1, 2'b10, 8'h90, 8'h00, 2'b11, 2'b10, 1'b1,
              1'b1, 8'h90, 1'b1, 1'b1, 1'b0);
        check("R10 protect same edge", {7'd0, abort}, 8'd1);

        // random phase, hits provoked by steering the address near a base
        for (int i = 0; i < 600; i++) begin
            logic do_cfg, sel, do_acc;
            do_cfg = ($urandom % 4) == 0;
            sel = 1'($urandom);
            r_base = 8'($urandom);
            r_mask = 8'($urandom) & (8'hFF >> ($urandom % 9));
            do_acc = ($urandom % 8) != 0;
            if (($urandom % 3) != 0)
                r_a = s_base[$urandom % 2] ^ (8'($urandom) & s_mask[$urandom % 2]);
            else
                r_a = 8'($urandom);
            cycle("R3 R4 R5 R7 R8 random", do_cfg, sel, ($urandom % 5) != 0, 2'($urandom),
                  r_base, r_mask, 2'($urandom), 2'($urandom), 1'($urandom),
                  do_acc, r_a, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule